// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Controller

This block sits between a power stage's protection comparators and its six gate outputs. It takes a synchronized overcurrent comparator bit and two synchronized supply-status bits. From these it produces one force-off signal for every gate output, and an active-low fault pin. The fault pin is modelled as the enable of an open-drain pull-down.

A short spike on the overcurrent input is rejected. The input has to stay high for a programmable number of consecutive clock cycles before it counts as a fault. A confirmed overcurrent latches a shutdown that lasts a fixed hold interval. When that interval ends, the block releases on its own, unless the overcurrent is still present. In that case it trips again at once and starts a new hold.

The supply is treated as a level condition with hysteresis kept in logic. Operation starts only after the supply reports above the upper threshold. It stops as soon as the supply reports below the lower threshold. The fault pin is shared by the latched overcurrent and the live undervoltage lockout. Both outputs come from a register, so they carry no combinational glitches.

Top module: `fault_guard`

## Requirements
- R1: A synchronous reset (`rst` high) leaves the block in lockout. Both `gateOff` and `faultPullDown` read 1 after the reset edge, and they stay at 1 until a supply code of `supplyHigh`=1 with `supplyLow`=0 is seen.
- R2: An overcurrent input that is high for fewer than FILT_CYCLES consecutive clock edges has no effect on the outputs. A single low sample restarts the count.
- R3: On the clock edge that samples the FILT_CYCLES-th consecutive high of `ocRaw`, the block trips. After that edge, `gateOff` and `faultPullDown` both read 1.
- R4: A trip keeps both outputs asserted for exactly HOLD_CYCLES clock cycles, even if `ocRaw` drops during that time.
- R5: If `ocRaw` has been high for at least FILT_CYCLES consecutive edges at the edge where the hold ends, the block trips again without a gap and runs a full new hold.
- R6: Lockout is left only on an edge that samples `supplyHigh`=1 and `supplyLow`=0. The status code {supplyHigh,supplyLow}=00 leaves the lockout state unchanged.
- R7: When running, an edge that samples `supplyLow`=1 enters lockout, whatever the value of `supplyHigh`. The codes 00 and 10 keep the block running.
- R8: Both outputs equal the OR of the lockout state and the trip state. Trip timing is independent of lockout: a trip started during lockout still holds for its full length after the lockout is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ocRaw | input | 1 | Synchronized overcurrent comparator result, 1 = over limit |
| supplyHigh | input | 1 | Supply reported above the upper threshold |
| supplyLow | input | 1 | Supply reported below the lower threshold |
| gateOff | output | 1 | Forces all six gate outputs off when 1 |
| faultPullDown | output | 1 | Enables the open-drain pull-down, so the fault pin reads low when 1 |

## Verification
The hardest case to reach is the retrip at the exact edge where the hold ends. The overcurrent input must then still be high, and high for long enough that the spike filter is saturated. A lower count of highs, or a drop just before the end of the hold, must instead give a clean release.

The stimulus reaches this case by sweeping pulse lengths one cycle at a time, with a small filter and hold configuration. The sweep crosses several multiples of the hold length. Expected output traces are computed from how many full holds fit into each pulse. Separate sequences overlap lockout with a running trip, in both orders.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;
  typedef struct packed {
    logic holdRestart;
    logic holdRun;
  } guardStrobes_t;
endpackage

// File: rtl/fault_guard_dp.sv
module fault_guard_dp
  import fault_guard_pkg::*;
#(
  parameter int FILT_CYCLES = 53,
  parameter int HOLD_CYCLES = 6500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ocRaw,
  input  guardStrobes_t strobes,
  output logic          ocConfirmed,
  output logic          holdDone
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYCLES - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [FW-1:0] filtCnt;
  logic [HW-1:0] holdCnt;

  // consecutive-high counter, saturating at the confirm point
  always_ff @(posedge clk) begin
    if (rst || !ocRaw) begin
      filtCnt <= '0;
    end else if (filtCnt != FILT_LAST) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  assign ocConfirmed = ocRaw && (filtCnt == FILT_LAST);

  // hold interval counter
  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (strobes.holdRestart) begin
      holdCnt <= '0;
    end else if (strobes.holdRun) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == HOLD_LAST);
endmodule

// File: rtl/fault_guard_ctl.sv
module fault_guard_ctl
  import fault_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          supplyHigh,
  input  logic          supplyLow,
  input  logic          ocConfirmed,
  input  logic          holdDone,
  output guardStrobes_t strobes,
  output logic          tripActive,
  output logic          lockoutActive,
  output logic          offOut
);
  logic tripNext;
  logic lockoutNext;

  always_comb begin
    if (!tripActive || holdDone) begin
      tripNext = ocConfirmed;
    end else begin
      tripNext = 1'b1;
    end
  end

  always_comb begin
    if (supplyLow) begin
      lockoutNext = 1'b1;
    end else if (supplyHigh) begin
      lockoutNext = 1'b0;
    end else begin
      lockoutNext = lockoutActive;
    end
  end

  always_comb begin
    strobes.holdRestart = ocConfirmed && (!tripActive || holdDone);
    strobes.holdRun     = tripActive;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tripActive    <= 1'b0;
      lockoutActive <= 1'b1;
      offOut        <= 1'b1;
    end else begin
      tripActive    <= tripNext;
      lockoutActive <= lockoutNext;
      offOut        <= tripNext || lockoutNext;
    end
  end
endmodule

// File: rtl/fault_guard.sv
module fault_guard
  import fault_guard_pkg::*;
#(
  parameter int FILT_CYCLES = 53,
  parameter int HOLD_CYCLES = 6500
) (
  input  logic clk,
  input  logic rst,
  input  logic ocRaw,
  input  logic supplyHigh,
  input  logic supplyLow,
  output logic gateOff,
  output logic faultPullDown
);
  guardStrobes_t strobes;
  logic ocConfirmed;
  logic holdDone;
  logic tripActive;
  logic lockoutActive;
  logic offOut;

  fault_guard_dp #(
    .FILT_CYCLES(FILT_CYCLES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) dp_i (
    .clk(clk),
    .rst(rst),
    .ocRaw(ocRaw),
    .strobes(strobes),
    .ocConfirmed(ocConfirmed),
    .holdDone(holdDone)
  );

  fault_guard_ctl ctl_i (
    .clk(clk),
    .rst(rst),
    .supplyHigh(supplyHigh),
    .supplyLow(supplyLow),
    .ocConfirmed(ocConfirmed),
    .holdDone(holdDone),
    .strobes(strobes),
    .tripActive(tripActive),
    .lockoutActive(lockoutActive),
    .offOut(offOut)
  );

  assign gateOff       = offOut;
  assign faultPullDown = offOut;
endmodule

// File: rtl/fault_guard_chk.sv
module fault_guard_chk #(
  parameter int FILT_CYCLES = 53,
  parameter int HOLD_CYCLES = 6500
) (
  input logic clk,
  input logic rst,
  input logic ocRaw,
  input logic supplyHigh,
  input logic supplyLow,
  input logic gateOff,
  input logic faultPullDown,
  input logic tripActive,
  input logic lockoutActive
);
  localparam int RW = $clog2(FILT_CYCLES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [RW-1:0] RUN_SAT   = RW'(FILT_CYCLES - 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic [RW-1:0] runCnt;
  logic [HW-1:0] holdAge;

  always_ff @(posedge clk) begin
    if (rst || !ocRaw) begin
      runCnt <= '0;
    end else if (runCnt != RUN_SAT) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !tripActive || holdAge == HOLD_LAST) begin
      holdAge <= '0;
    end else begin
      holdAge <= holdAge + 1'b1;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (gateOff && faultPullDown && lockoutActive));

  p_filter_run_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tripActive) |-> ($past(ocRaw) && $past(runCnt) == RUN_SAT));

  p_hold_length_r4: assert property (@(posedge clk) disable iff (rst)
    (tripActive && holdAge != HOLD_LAST) |=> tripActive);

  p_retrip_r5: assert property (@(posedge clk) disable iff (rst)
    (tripActive && holdAge == HOLD_LAST && ocRaw && runCnt == RUN_SAT) |=> tripActive);

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(lockoutActive) |-> $past(supplyHigh && !supplyLow));

  p_lockout_entry_r7: assert property (@(posedge clk) disable iff (rst)
    supplyLow |=> lockoutActive);

  p_outputs_on_r8: assert property (@(posedge clk) disable iff (rst)
    (tripActive || lockoutActive) |-> (gateOff && faultPullDown));

  p_outputs_off_r8: assert property (@(posedge clk) disable iff (rst)
    !(tripActive || lockoutActive) |-> (!gateOff && !faultPullDown));
endmodule

bind fault_guard fault_guard_chk #(
  .FILT_CYCLES(FILT_CYCLES),
  .HOLD_CYCLES(HOLD_CYCLES)
) chk_i (
  .clk(clk),
  .rst(rst),
  .ocRaw(ocRaw),
  .supplyHigh(supplyHigh),
  .supplyLow(supplyLow),
  .gateOff(gateOff),
  .faultPullDown(faultPullDown),
  .tripActive(tripActive),
  .lockoutActive(lockoutActive)
);

// File: tb/fault_guard_tb_top.sv
module fault_guard_tb_top;
  localparam int F = 4;
  localparam int H = 10;
  localparam time PERIOD = 4ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ocRaw = 1'b0;
  logic supplyHigh = 1'b0;
  logic supplyLow = 1'b0;
  logic gateOff;
  logic faultPullDown;

  int vectors = 0;
  int miscompares = 0;

  always #(PERIOD / 2) clk = ~clk;

  fault_guard #(.FILT_CYCLES(F), .HOLD_CYCLES(H)) dut_i (
    .clk(clk),
    .rst(rst),
    .ocRaw(ocRaw),
    .supplyHigh(supplyHigh),
    .supplyLow(supplyLow),
    .gateOff(gateOff),
    .faultPullDown(faultPullDown)
  );

  // code[1] = supplyHigh, code[0] = supplyLow
  task automatic step(input logic oc, input logic [1:0] code);
    ocRaw = oc;
    supplyHigh = code[1];
    supplyLow = code[0];
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic expOff, input string req);
    vectors++;
    if (gateOff !== expOff || faultPullDown !== expOff) begin
      miscompares++;
      $display("FAIL %s: gateOff=%b faultPullDown=%b expected %b at %0t",
               req, gateOff, faultPullDown, expOff, $time);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    miscompares++;
    $display("FAIL all requirements (watchdog): finished=0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic lockState;
    // R1: reset state, lockout held with an in-between supply code
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b1, "R1");
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 2'b00);
      check(1'b1, "R1");
    end
    step(1'b0, 2'b01);
    check(1'b1, "R1");

    // R6 / R7: every status code from each lockout state
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [1:0] code;
        logic expLock;
        code = 2'(c);
        step(1'b0, (s == 0) ? 2'b01 : 2'b10);
        lockState = (s == 0);
        check(lockState, (s == 0) ? "R6" : "R7");
        step(1'b0, code);
        expLock = code[0] ? 1'b1 : (code[1] ? 1'b0 : lockState);
        check(expLock, lockState ? "R6" : "R7");
        step(1'b0, 2'b00);
        check(expLock, lockState ? "R6" : "R7");
      end
    end

    // R2-R5: pulse width sweep while running
    step(1'b0, 2'b10);
    check(1'b0, "R6");
    for (int w = 1; w <= 35; w++) begin
      int m;
      m = (w >= F) ? 1 + (w - F) / H : 0;
      for (int i = 0; i <= w + 2 * H + 4; i++) begin
        logic expOff;
        step(i < w, 2'b10);
        expOff = (m > 0) && (i >= F - 1) && (i < F - 1 + H * m);
        if (m == 0)
          check(expOff, "R2");
        else if (i < F - 1 + H)
          check(expOff, "R3/R4");
        else if (m > 1)
          check(expOff, "R5");
        else
          check(expOff, "R4");
      end
    end

    // R2: broken pulses never confirm
    for (int i = 0; i < F - 1; i++) begin step(1'b1, 2'b10); check(1'b0, "R2"); end
    step(1'b0, 2'b10); check(1'b0, "R2");
    for (int i = 0; i < F - 1; i++) begin step(1'b1, 2'b10); check(1'b0, "R2"); end
    for (int i = 0; i < 5; i++) begin step(1'b0, 2'b10); check(1'b0, "R2"); end

    // R8: trip started in lockout outlives the lockout
    for (int i = 0; i <= F + H + 2; i++) begin
      step(i < F, (i < F + 3) ? 2'b01 : 2'b10);
      check(i < F + H - 1, "R8");
    end

    // R8: lockout entered during a running trip outlives the trip
    for (int i = 0; i <= F + H + 6; i++) begin
      logic inUv;
      inUv = (i >= F + 2) && (i < F + H + 3);
      step(i < F, inUv ? 2'b01 : 2'b10);
      check(((i >= F - 1) && (i < F - 1 + H)) || inUv, "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule